// File: doc/BRIEF.md
# Full-Duplex Serial Master with Slave Request Handshake

This block is a serial master for a processor subsystem. The host loads one word into a transmit holding register; when the engine is free, that word moves into a shift register. The engine then produces a burst of serial clock pulses. It drives the word out on `mosi`, most significant bit first, and at the same time captures the same number of bits from `miso`. Every transfer is therefore full duplex. A transfer starts only when the host writes a word, even if the host only wants the received data. Each received word goes into a four-entry receive queue that the host drains.

The transmit side is a valid/ready input. A word is taken on a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` doubles as the transmit-empty status. The host must keep `tx_data` steady while `tx_valid` waits. The receive side is a valid/ready output. `rx_valid` doubles as the receive-not-empty status, and a word leaves the queue on a cycle where `rx_valid` and `rx_ready` are both high. The block has no way to stall the serial side. If the queue is full when a word completes, that word is dropped and a sticky error flag is raised.

An optional request line from the slave gates the start of each word. A nonzero request-enable field makes the master wait for the slave to assert the line. The slave drops the line on the first clock of the word, and the master then holds the next word back until the line returns. A word that has begun always finishes. Configuration inputs must not change while a word is in flight. Dropping `en` is a soft reset of the data path.

Top module: `spi_hs_master`

## Requirements
- R1: `tx_ready` is high exactly when `en` is high and the holding register is empty. It falls in the cycle after a write is accepted and rises in the cycle after the word moves into the shift register.
- R2: With the engine idle, `sclk` rests at `cpol`. A held word starts one cycle after the start condition is met. Each `sclk` half period lasts `clk_div`+1 system clocks, and a word of N bits makes 2N edges.
- R3: `mosi` sends the word MSB first. With `cpha`=0 each bit is valid from the start of the word or from the trailing edge that precedes it. With `cpha`=1 each bit changes on a leading edge.
- R4: `miso` is sampled on leading edges when `cpha`=0 and on trailing edges when `cpha`=1. The N-bit word is queued at the last edge. `rx_valid` is high while the queue holds a word, `rx_data` shows the oldest word, and a read removes that word.
- R5: The queue holds 4 words. A completed word that finds the queue full, with no read in the same cycle, is discarded and sets `rx_ovr`. `rx_ovr` stays set until `en` falls.
- R6: With `req_en`=2'b00, `slv_req` has no effect. With any bit of `req_en` set, a word starts only while `slv_req`, after two synchroniser flops, is high. A word that has begun completes whatever `slv_req` does.
- R7: The `word_len` codes are 2'b00 for 8 bits, 2'b01 for 16 bits, and 2'b10 or 2'b11 for 24 bits. Transmit and receive words are right aligned in `tx_data` and `rx_data`.
- R8: `irq` is (`ie_tx` AND `tx_ready`) OR (`ie_rx` AND `rx_valid`) OR (`ie_err` AND `rx_ovr`).
- R9: While `en` is low, the queue, the holding register, the engine and `rx_ovr` are cleared, and `sclk` follows `cpol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Interface enable; low acts as a soft reset |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| clk_div | input | 8 | Half period of the serial clock minus one, in system clocks |
| word_len | input | 2 | Word length code (see R7) |
| req_en | input | 2 | Slave request enable; zero ignores `slv_req` |
| ie_tx | input | 1 | Interrupt mask for transmit empty |
| ie_rx | input | 1 | Interrupt mask for receive not empty |
| ie_err | input | 1 | Interrupt mask for the overrun error |
| tx_data | input | 24 | Word to transmit, right aligned |
| tx_valid | input | 1 | Host offers `tx_data` |
| tx_ready | output | 1 | Holding register empty (transmit empty) |
| rx_data | output | 24 | Oldest received word, right aligned |
| rx_valid | output | 1 | Receive queue not empty |
| rx_ready | input | 1 | Host takes `rx_data` |
| rx_ovr | output | 1 | Sticky receive overrun (bus error) |
| irq | output | 1 | Combined masked interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| slv_req | input | 1 | Asynchronous ready request from the slave |

## Verification
A wrong edge counter or divider count shows on `sclk` within one half period: an extra or missing toggle, or a word that runs too long. A shift register that loads or moves wrongly puts a bad bit on `mosi` at the first affected edge. A capture error surfaces as a wrong `rx_data` word in the cycle after the word completes. A queue pointer or count fault shows on `rx_data` or `rx_valid` at the next read, and a stale holding flag shows on `tx_ready` one cycle after the write or the start.

// File: rtl/spi_hs_pkg.sv
package spi_hs_pkg;
  localparam int WORD_W = 24;
  localparam int BITS_W = $clog2(WORD_W + 1);

  typedef enum logic [1:0] {
    WL_8   = 2'b00,
    WL_16  = 2'b01,
    WL_24  = 2'b10,
    WL_24X = 2'b11
  } wl_code_e;

  function automatic logic [BITS_W-1:0] wl_to_bits(input logic [1:0] code);
    case (wl_code_e'(code))
      WL_8:    return BITS_W'(8);
      WL_16:   return BITS_W'(16);
      default: return BITS_W'(24);
    endcase
  endfunction
endpackage

// File: rtl/spi_hs_clkdiv.sv
module spi_hs_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/spi_hs_engine.sv
module spi_hs_engine
  import spi_hs_pkg::*;
#(
  parameter int W    = WORD_W,
  parameter int NB_W = BITS_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            cpol,
  input  logic            cpha,
  input  logic [NB_W-1:0] nbits,
  input  logic            start,
  input  logic [W-1:0]    start_word,
  input  logic            tick,
  input  logic            miso,
  output logic            busy,
  output logic            sclk,
  output logic            mosi,
  output logic            done,
  output logic [W-1:0]    rx_word
);
  localparam int EDGE_W = $clog2(2 * W + 1);

  logic [EDGE_W-1:0] edge_cnt;
  logic [EDGE_W-1:0] last_idx;
  logic [W-1:0]      sr;
  logic [W-1:0]      rxs;
  logic [W-1:0]      rx_next;
  logic [W-1:0]      mask;
  logic [NB_W-1:0]   shamt;
  logic              sclk_q;
  logic              mosi_q;
  logic              busy_q;
  logic              samp;

  assign shamt    = NB_W'(W) - nbits;
  assign mask     = {W{1'b1}} >> shamt;
  assign last_idx = EDGE_W'({nbits, 1'b0}) - EDGE_W'(1);
  // even edge index = leading edge; sampling edge depends on phase
  assign samp     = (~edge_cnt[0]) ^ cpha;
  assign rx_next  = samp ? {rxs[W-2:0], miso} : rxs;
  assign done     = busy_q && tick && (edge_cnt == last_idx);
  assign rx_word  = rx_next & mask;

  assign busy = busy_q;
  assign sclk = sclk_q;
  assign mosi = cpha ? mosi_q : sr[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      edge_cnt <= '0;
      sclk_q   <= 1'b0;
      mosi_q   <= 1'b0;
      sr       <= '0;
      rxs      <= '0;
    end else if (clr) begin
      busy_q   <= 1'b0;
      edge_cnt <= '0;
      sclk_q   <= cpol;
    end else if (start) begin
      busy_q   <= 1'b1;
      edge_cnt <= '0;
      sclk_q   <= cpol;
      sr       <= start_word << shamt;
      rxs      <= '0;
    end else if (busy_q && tick) begin
      edge_cnt <= edge_cnt + EDGE_W'(1);
      sclk_q   <= ~sclk_q;
      rxs      <= rx_next;
      if (!samp) begin
        mosi_q <= sr[W-1];
        sr     <= {sr[W-2:0], 1'b0};
      end
      if (edge_cnt == last_idx) begin
        busy_q <= 1'b0;
      end
    end else if (!busy_q) begin
      sclk_q <= cpol;
    end
  end
endmodule

// File: rtl/spi_hs_rxfifo.sv
module spi_hs_rxfifo #(
  parameter int W     = 24,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         not_empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp;
  logic [AW-1:0] rp;
  logic [CW-1:0] cnt;
  logic          do_pop;
  logic          do_push;

  assign not_empty = (cnt != '0);
  assign full      = (cnt == CW'(DEPTH));
  assign do_pop    = pop && not_empty;
  assign do_push   = push && (!full || do_pop);
  assign rdata     = mem[rp];

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) begin
      mem[wp] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wrap_inc(wp);
      if (do_pop)  rp <= wrap_inc(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/spi_hs_master.sv
module spi_hs_master
  import spi_hs_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int FIFO_DEPTH  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic [1:0]        word_len,
  input  logic [1:0]        req_en,
  input  logic              ie_tx,
  input  logic              ie_rx,
  input  logic              ie_err,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              rx_ovr,
  output logic              irq,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  input  logic              slv_req
);
  logic [WORD_W-1:0]      hold_data;
  logic                   hold_full;
  logic [SYNC_STAGES-1:0] req_pipe;
  logic                   req_sync;
  logic                   req_gate;
  logic [BITS_W-1:0]      nbits;
  logic                   eng_start;
  logic                   eng_busy;
  logic                   eng_done;
  logic                   div_tick;
  logic [WORD_W-1:0]      eng_rx_word;
  logic                   rx_push;
  logic                   rx_pop;
  logic                   fifo_full;
  logic                   ovr_q;

  // request line synchroniser
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          req_pipe[gi] <= 1'b0;
        end else if (gi == 0) begin
          req_pipe[gi] <= slv_req;
        end else begin
          req_pipe[gi] <= req_pipe[(gi == 0) ? 0 : gi - 1];
        end
      end
    end
  endgenerate

  assign req_sync  = req_pipe[SYNC_STAGES-1];
  assign req_gate  = (req_en == 2'b00) || req_sync;
  assign nbits     = wl_to_bits(word_len);
  assign eng_start = en && !eng_busy && hold_full && req_gate;
  assign tx_ready  = en && !hold_full;
  assign rx_pop    = rx_valid && rx_ready;
  assign rx_push   = eng_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (!en) begin
      hold_full <= 1'b0;
    end else if (tx_valid && tx_ready) begin
      hold_full <= 1'b1;
      hold_data <= tx_data;
    end else if (eng_start) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
    end else if (!en) begin
      ovr_q <= 1'b0;
    end else if (rx_push && fifo_full && !rx_pop) begin
      ovr_q <= 1'b1;
    end
  end

  spi_hs_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (eng_busy && en),
    .div   (clk_div),
    .tick  (div_tick)
  );

  spi_hs_engine #(.W(WORD_W), .NB_W(BITS_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (!en),
    .cpol       (cpol),
    .cpha       (cpha),
    .nbits      (nbits),
    .start      (eng_start),
    .start_word (hold_data),
    .tick       (div_tick),
    .miso       (miso),
    .busy       (eng_busy),
    .sclk       (sclk),
    .mosi       (mosi),
    .done       (eng_done),
    .rx_word    (eng_rx_word)
  );

  spi_hs_rxfifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (!en),
    .push      (rx_push),
    .wdata     (eng_rx_word),
    .pop       (rx_pop),
    .rdata     (rx_data),
    .not_empty (rx_valid),
    .full      (fifo_full)
  );

  assign rx_ovr = ovr_q;
  assign irq    = (ie_tx && tx_ready) || (ie_rx && rx_valid) || (ie_err && ovr_q);
endmodule

// File: rtl/spi_hs_chk.sv
module spi_hs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       cpol,
  input logic [1:0] req_en,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       rx_ovr,
  input logic       sclk,
  input logic       busy,
  input logic       req_sync,
  input logic       push
);
  AST_TX_FULL_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready); // R1

  AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (busy || (sclk == $past(cpol)))); // R2

  AST_RX_NONEMPTY_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (push && en) |=> rx_valid); // R4

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovr && en) |=> rx_ovr); // R5

  AST_REQ_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (req_en != 2'b00) && !req_sync && !busy) |=> !busy); // R6

  AST_EN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!rx_valid && !rx_ovr)); // R9
endmodule

bind spi_hs_master spi_hs_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .cpol     (cpol),
  .req_en   (req_en),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .rx_valid (rx_valid),
  .rx_ovr   (rx_ovr),
  .sclk     (sclk),
  .busy     (eng_busy),
  .req_sync (req_sync),
  .push     (rx_push)
);

// File: tb/spi_hs_master_tb.sv
`timescale 1ns/1ps
module spi_hs_master_tb;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        cpol = 1'b0;
  logic        cpha = 1'b0;
  logic [7:0]  clk_div = 8'd1;
  logic [1:0]  word_len = 2'b00;
  logic [1:0]  req_en = 2'b00;
  logic        ie_tx = 1'b0;
  logic        ie_rx = 1'b0;
  logic        ie_err = 1'b0;
  logic [23:0] tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [23:0] rx_data;
  logic        rx_valid;
  logic        rx_ready = 1'b0;
  logic        rx_ovr;
  logic        irq;
  logic        sclk;
  logic        mosi;
  logic        miso = 1'b0;
  logic        slv_req = 1'b0;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  spi_hs_master u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol), .cpha(cpha),
    .clk_div(clk_div), .word_len(word_len), .req_en(req_en),
    .ie_tx(ie_tx), .ie_rx(ie_rx), .ie_err(ie_err),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_ovr(rx_ovr), .irq(irq), .sclk(sclk), .mosi(mosi),
    .miso(miso), .slv_req(slv_req)
  );

  // ---------------- behavioural reference ----------------
  bit          m_hold;
  logic [23:0] m_hold_data;
  bit          m_busy;
  int          m_cnt;
  int          m_e;
  bit          m_sclk;
  logic [23:0] m_word;
  logic [23:0] m_slave;
  logic [23:0] m_q[$];
  bit          m_ovr;
  bit          m_rs1;
  bit          m_rs2;

  function automatic int nbits_of(input logic [1:0] c);
    return (c == 2'b00) ? 8 : (c == 2'b01) ? 16 : 24;
  endfunction

  function automatic logic [23:0] mask_of(input int n);
    return 24'hFFFFFF >> (24 - n);
  endfunction

  function automatic logic [23:0] slave_word(input logic [23:0] d, input int n);
    return (d ^ 24'h5AC369) & mask_of(n);
  endfunction

  always @(posedge clk) begin
    bit nrs1;
    bit nrs2;
    nrs1 = slv_req;
    nrs2 = m_rs1;
    if (!rst_n) begin
      m_hold = 0; m_busy = 0; m_cnt = 0; m_e = 0; m_sclk = 0;
      m_q.delete(); m_ovr = 0; nrs1 = 0; nrs2 = 0;
    end else if (!en) begin
      m_hold = 0; m_busy = 0; m_cnt = 0; m_e = 0; m_sclk = cpol;
      m_q.delete(); m_ovr = 0;
    end else begin
      int  n;
      bit  pop;
      bit  full_b;
      bit  wr;
      bit  start;
      bit  push;
      n = nbits_of(word_len);
      pop = rx_ready && (m_q.size() > 0);
      full_b = (m_q.size() == DEPTH);
      wr = tx_valid && !m_hold;
      start = !m_busy && m_hold && ((req_en == 2'b00) || m_rs2);
      push = 0;
      if (m_busy) begin
        if (m_cnt == int'(clk_div)) begin
          m_cnt = 0;
          m_sclk = !m_sclk;
          if (m_e == 2 * n - 1) begin
            m_busy = 0;
            push = 1;
          end
          m_e = m_e + 1;
        end else begin
          m_cnt = m_cnt + 1;
        end
      end else begin
        m_sclk = cpol;
      end
      if (start) begin
        m_busy = 1; m_cnt = 0; m_e = 0; m_hold = 0;
        m_word = m_hold_data & mask_of(n);
        m_slave = slave_word(m_hold_data, n);
      end
      if (wr) begin
        m_hold = 1;
        m_hold_data = tx_data;
      end
      if (pop) void'(m_q.pop_front());
      if (push) begin
        if (!full_b || pop) m_q.push_back(m_slave);
        else m_ovr = 1;
      end
    end
    m_rs1 = nrs1;
    m_rs2 = nrs2;
  end

  // bit index currently on the wire, -1 when none is defined
  function automatic int cur_bit();
    if (!m_busy) return -1;
    if (!cpha) return m_e / 2;
    if (m_e == 0) return -1;
    return (m_e + 1) / 2 - 1;
  endfunction

  // slave side: drive miso from the reference word
  always @(negedge clk) begin
    int k;
    int n;
    k = cur_bit();
    n = nbits_of(word_len);
    miso <= (k >= 0) ? m_slave[n - 1 - k] : 1'b0;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // per-cycle comparison, a quarter period after the active edge
  bit compare_on = 0;
  always begin
    @(posedge clk);
    #5;
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all) actual=timeout expected=completion");
      finish_run();
    end
    if (rst_n && compare_on) begin
      int k;
      int n;
      bit exp_txr;
      bit exp_rxv;
      bit exp_irq;
      n = nbits_of(word_len);
      exp_txr = en && !m_hold;
      exp_rxv = (m_q.size() > 0);
      exp_irq = (ie_tx && exp_txr) || (ie_rx && exp_rxv) || (ie_err && m_ovr);
      chk(tx_ready == exp_txr, "R1", "tx_ready", tx_ready, exp_txr);
      chk(sclk == m_sclk, "R2", "sclk", sclk, m_sclk);
      chk(rx_valid == exp_rxv, "R4", "rx_valid", rx_valid, exp_rxv);
      if (exp_rxv) chk(rx_data == m_q[0], "R4/R7", "rx_data", rx_data, m_q[0]);
      chk(rx_ovr == m_ovr, "R5", "rx_ovr", rx_ovr, m_ovr);
      chk(irq == exp_irq, "R8", "irq", irq, exp_irq);
      k = cur_bit();
      if (k >= 0) chk(mosi == m_word[n - 1 - k], "R3", "mosi", mosi, m_word[n - 1 - k]);
    end
  end

  // ---------------- stimulus helpers (called at negedge) ----------------
  task automatic cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic put(input logic [23:0] d);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1;
    tx_data = d;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic settle();
    while (m_busy || m_hold) @(negedge clk);
    cyc(2);
  endtask

  task automatic drain();
    rx_ready = 1'b1;
    do @(negedge clk); while (rx_valid);
    rx_ready = 1'b0;
  endtask

  task automatic soft_reset();
    en = 1'b0;
    cyc(2);
    en = 1'b1;
    cyc(1);
  endtask

  initial begin
    cyc(3);
    // reset state (R9: disabled block idles)
    chk(tx_ready == 1'b0, "R9", "tx_ready at reset", tx_ready, 0);
    chk(rx_valid == 1'b0, "R9", "rx_valid at reset", rx_valid, 0);
    chk(sclk == 1'b0, "R2", "sclk at reset", sclk, 0);
    chk(irq == 1'b0, "R8", "irq at reset", irq, 0);
    rst_n = 1'b1;
    cyc(2);
    compare_on = 1;
    en = 1'b1;
    ie_rx = 1'b1;
    cyc(2);

    // mode 0, 8-bit, back to back
    cpol = 0; cpha = 0; clk_div = 8'd1; word_len = 2'b00;
    put(24'h0000A5);
    put(24'h00003C);
    settle();
    chk(rx_data == slave_word(24'h0000A5, 8), "R7", "8-bit rx word", rx_data, slave_word(24'h0000A5, 8));
    drain();

    // mode 1, 16-bit
    cpha = 1; word_len = 2'b01; clk_div = 8'd0;
    cyc(2);
    put(24'h00C3E1);
    put(24'h001234);
    settle();
    chk(rx_data == slave_word(24'h00C3E1, 16), "R7", "16-bit rx word", rx_data, slave_word(24'h00C3E1, 16));
    drain();

    // mode 2 and 3, 24-bit, slower clock, both 24-bit codes
    cpol = 1; cpha = 0; word_len = 2'b10; clk_div = 8'd3; ie_tx = 1;
    cyc(2);
    put(24'h8F0F71);
    settle();
    chk(rx_data == slave_word(24'h8F0F71, 24), "R7", "24-bit rx word", rx_data, slave_word(24'h8F0F71, 24));
    cpha = 1; word_len = 2'b11; clk_div = 8'd2;
    cyc(2);
    put(24'h13579B);
    settle();
    drain();
    ie_tx = 0;

    // overrun: five words without reading
    cpol = 0; cpha = 0; word_len = 2'b00; clk_div = 8'd0; ie_err = 1; ie_rx = 0;
    cyc(2);
    for (int i = 0; i < 5; i++) put(24'(8'h11 * (i + 1)));
    settle();
    chk(rx_ovr == 1'b1, "R5", "overrun flag after 5 words", rx_ovr, 1);
    chk(rx_data == slave_word(24'h11, 8), "R5", "oldest word kept", rx_data, slave_word(24'h11, 8));
    chk(irq == 1'b1, "R8", "error interrupt", irq, 1);
    drain();
    chk(rx_ovr == 1'b1, "R5", "overrun sticky after drain", rx_ovr, 1);

    // soft reset clears queue and flag
    put(24'h42);
    settle();
    en = 1'b0;
    cyc(1);
    chk(rx_valid == 1'b0, "R9", "queue flushed", rx_valid, 0);
    chk(rx_ovr == 1'b0, "R9", "overrun cleared", rx_ovr, 0);
    chk(tx_ready == 1'b0, "R9", "tx_ready low while disabled", tx_ready, 0);
    en = 1'b1;
    cyc(2);
    ie_err = 0;

    // request ignored when disabled
    slv_req = 0; req_en = 2'b00;
    put(24'h66);
    settle();
    chk(rx_valid == 1'b1, "R6", "word ran with request low and gate off", rx_valid, 1);
    drain();

    // request handshake, cpha=1
    cpha = 1; req_en = 2'b01; clk_div = 8'd1; word_len = 2'b01;
    cyc(4);
    put(24'h0ACE);
    cyc(30);
    chk(tx_ready == 1'b0, "R6", "word held while request low", tx_ready, 0);
    chk(sclk == cpol, "R6", "no clocks while request low", sclk, cpol);
    slv_req = 1;
    while (!(m_busy && m_e >= 1)) @(negedge clk);
    slv_req = 0;
    put(24'hBEEF);
    while (m_busy) @(negedge clk);
    cyc(30);
    chk(tx_ready == 1'b0, "R6", "next word waits for request", tx_ready, 0);
    chk(rx_valid == 1'b1, "R6", "first word completed", rx_valid, 1);
    slv_req = 1;
    while (!(m_busy && m_e >= 10)) @(negedge clk);
    slv_req = 0;
    settle();
    chk(rx_data == slave_word(24'h0ACE, 16), "R6", "handshake word data", rx_data, slave_word(24'h0ACE, 16));
    drain();

    // other request-enable code also gates
    req_en = 2'b10;
    cyc(4);
    put(24'h5555);
    cyc(20);
    chk(tx_ready == 1'b0, "R6", "upper enable bit gates", tx_ready, 0);
    slv_req = 1;
    settle();
    slv_req = 0;
    drain();
    req_en = 2'b00;
    soft_reset();

    cyc(10);
    finish_run();
  end
endmodule